// File: doc/BRIEF.md
# Toggle-Clear Interrupt Status Unit

This block is the interrupt front end of a FIFO-based serial peripheral. Single-cycle event pulses from the transmit and receive paths are captured into a sticky status register. Each status bit is qualified by a matching bit in a per-bit enable register. The combined result is then gated by one global enable bit and drives a single level-sensitive interrupt line. The FIFOs and the shifting engine sit outside this block. They supply only the pulses and two level conditions: receive data available, and receive storage full.

Software reaches three registers through a simple select/read/write port. A write to the status register does not clear bits directly. The written word is XOR-ed into the stored bits, so writing back a value just read clears exactly those bits. Every register access, read or write, folds the current receive-available and receive-full levels into the status register. Between accesses those levels leave the status unchanged. The interrupt line is registered and is reloaded only when its computed level differs from the value it holds.

Top module: `tgl_irq_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, status, enable and global enable read zero and `irq` is low until state is changed.
- R2: A pulse on `ev_overrun`, `ev_underrun` or `ev_half_empty` sets status bit 5, 3 or 6 respectively on the next clock edge. The bit then stays set with no further pulse.
- R3: A pulse on `ev_tx_byte` sets status bits 2 and 8. A pulse on `ev_rx_fill` sets status bit 4.
- R4: A write with `reg_sel`=0 XORs `reg_wdata` into the status bits 2, 3, 4, 5, 6 and 8. All other status bits always read zero.
- R5: On any cycle with `reg_rd` or `reg_wr` high (any `reg_sel`), a high `lvl_rx_avail` sets status bit 8 and a high `lvl_rx_full` sets status bit 4. With no access, the levels have no effect on status.
- R6: When an event pulse and a status write toggle the same bit in one cycle, the bit ends up set.
- R7: A write with `reg_sel`=1 stores `reg_wdata` into the enable bits at the same six positions, and other enable bits read zero. A write with `reg_sel`=2 stores bit 31 as the global enable, and that register reads zero in bits 30..0.
- R8: `irq` equals global enable AND (status AND enable nonzero), as evaluated on the state held one clock earlier.
- R9: `reg_rdata` is combinational from the selected register's current contents. A read returns the value from before that cycle's own update.
- R10: `reg_sel`=3 reads zero, and a write with `reg_sel`=3 changes no register other than the level capture of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_byte | input | 1 | Pulse: one byte shifted out |
| ev_rx_fill | input | 1 | Pulse: received byte filled the receive storage |
| ev_overrun | input | 1 | Pulse: received byte lost to full storage |
| ev_underrun | input | 1 | Pulse: transmit ran dry |
| ev_half_empty | input | 1 | Pulse: transmit storage half drained |
| lvl_rx_avail | input | 1 | Level: receive storage not empty |
| lvl_rx_full | input | 1 | Level: receive storage full |
| reg_sel | input | 2 | 0 status, 1 enable, 2 global enable, 3 unused |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Level interrupt line |

## Verification
The status register can be hit in a single cycle by a hardware event, a software toggle and the access-driven level capture. The bench drives these together on purpose. One case is a status write of ones while `ev_rx_fill` and `ev_tx_byte` pulse, with both receive levels high. The bench judges the outcome against a behavioural model in which set sources are applied after the toggle. A long random phase then lets strobes, levels and events collide freely. It compares `reg_rdata` and `irq` with the model on every clock, so any ordering slip between toggle, event and capture shows up as a mismatch.

// File: rtl/tgl_irq_pkg.sv
package tgl_irq_pkg;

  localparam int unsigned REG_W = 32;

  // status / enable bit positions (decoded by software)
  localparam int unsigned B_TX_EMPTY = 2;
  localparam int unsigned B_TX_UNDER = 3;
  localparam int unsigned B_RX_FULL  = 4;
  localparam int unsigned B_RX_OVER  = 5;
  localparam int unsigned B_TX_HALF  = 6;
  localparam int unsigned B_RX_AVAIL = 8;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << B_TX_EMPTY) | (REG_W'(1) << B_TX_UNDER) |
      (REG_W'(1) << B_RX_FULL)  | (REG_W'(1) << B_RX_OVER)  |
      (REG_W'(1) << B_TX_HALF)  | (REG_W'(1) << B_RX_AVAIL);

  typedef enum logic [1:0] {
    SEL_STAT   = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_GLOBAL = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic tx_byte;
    logic rx_fill;
    logic rx_over;
    logic tx_under;
    logic tx_half;
  } evt_t;

endpackage

// File: rtl/tgl_irq_status.sv
module tgl_irq_status
  import tgl_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  evt_t         evt,
  input  logic         lvl_avail,
  input  logic         lvl_full,
  input  logic         acc,
  input  logic         tgl_we,
  input  logic [W-1:0] tgl_val,
  output logic [W-1:0] stat_q
);

  localparam logic [W-1:0] IMPL = W'(IMPL_MASK);

  logic [W-1:0] set_v;
  logic [W-1:0] tog_v;
  logic [W-1:0] stat_d;
  logic         stat_en;

  // set sources: event pulses plus levels captured on an access
  always_comb begin
    set_v             = '0;
    set_v[B_TX_EMPTY] = evt.tx_byte;
    set_v[B_RX_AVAIL] = evt.tx_byte | (acc & lvl_avail);
    set_v[B_RX_FULL]  = evt.rx_fill | (acc & lvl_full);
    set_v[B_RX_OVER]  = evt.rx_over;
    set_v[B_TX_UNDER] = evt.tx_under;
    set_v[B_TX_HALF]  = evt.tx_half;
  end

  // toggle first, then OR the set sources: a same-cycle event wins
  always_comb begin
    tog_v   = tgl_we ? (tgl_val & IMPL) : '0;
    stat_d  = ((stat_q ^ tog_v) | set_v) & IMPL;
    stat_en = tgl_we | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

endmodule

// File: rtl/tgl_irq_cfg.sv
module tgl_irq_cfg
  import tgl_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic         gie_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic         gie_q
);

  localparam logic [W-1:0] IMPL    = W'(IMPL_MASK);
  localparam int unsigned  GIE_POS = W - 1;

  logic [W-1:0] en_d;
  logic         gie_d;

  always_comb begin
    en_d  = wdata & IMPL;
    gie_d = wdata[GIE_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
    end else if (gie_we) begin
      gie_q <= gie_d;
    end
  end

endmodule

// File: rtl/tgl_irq_line.sv
module tgl_irq_line #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_q,
  input  logic [W-1:0] en_q,
  input  logic         gie_q,
  output logic         irq_q
);

  logic lvl_d;
  logic chg;

  always_comb begin
    lvl_d = gie_q & (|(stat_q & en_q));
    chg   = lvl_d ^ irq_q;
  end

  // reload only on a change of the computed level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (chg) begin
      irq_q <= lvl_d;
    end
  end

endmodule

// File: rtl/tgl_irq_unit.sv
module tgl_irq_unit
  import tgl_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_tx_byte,
  input  logic         ev_rx_fill,
  input  logic         ev_overrun,
  input  logic         ev_underrun,
  input  logic         ev_half_empty,
  input  logic         lvl_rx_avail,
  input  logic         lvl_rx_full,
  input  logic [1:0]   reg_sel,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq
);

  reg_sel_e     sel;
  evt_t         evt;
  logic         acc;
  logic         stat_we;
  logic         en_we;
  logic         gie_we;
  logic [W-1:0] stat_q;
  logic [W-1:0] en_q;
  logic         gie_q;

  always_comb begin
    sel          = reg_sel_e'(reg_sel);
    evt.tx_byte  = ev_tx_byte;
    evt.rx_fill  = ev_rx_fill;
    evt.rx_over  = ev_overrun;
    evt.tx_under = ev_underrun;
    evt.tx_half  = ev_half_empty;
    acc          = reg_rd | reg_wr;
    stat_we      = reg_wr & (sel == SEL_STAT);
    en_we        = reg_wr & (sel == SEL_MASK);
    gie_we       = reg_wr & (sel == SEL_GLOBAL);
  end

  always_comb begin
    unique case (sel)
      SEL_STAT:   reg_rdata = stat_q;
      SEL_MASK:   reg_rdata = en_q;
      SEL_GLOBAL: reg_rdata = {gie_q, {(W-1){1'b0}}};
      default:    reg_rdata = '0;
    endcase
  end

  tgl_irq_status #(.W(W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .lvl_avail (lvl_rx_avail),
    .lvl_full  (lvl_rx_full),
    .acc       (acc),
    .tgl_we    (stat_we),
    .tgl_val   (reg_wdata),
    .stat_q    (stat_q)
  );

  tgl_irq_cfg #(.W(W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (en_we),
    .gie_we (gie_we),
    .wdata  (reg_wdata),
    .en_q   (en_q),
    .gie_q  (gie_q)
  );

  tgl_irq_line #(.W(W)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_q (stat_q),
    .en_q   (en_q),
    .gie_q  (gie_q),
    .irq_q  (irq)
  );

endmodule

// File: rtl/tgl_irq_unit_chk.sv
module tgl_irq_unit_chk
  import tgl_irq_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ev_overrun,
  input logic         ev_tx_byte,
  input logic         lvl_rx_full,
  input logic         reg_rd,
  input logic         reg_wr,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] en_q,
  input logic         gie_q,
  input logic         irq
);

  localparam logic [W-1:0] IMPL = W'(IMPL_MASK);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      irq_low_in_reset_chk: assert (irq == 1'b0);
    end
  end

  // R8
  irq_follows_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(gie_q & (|(stat_q & en_q))));

  // R2
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> stat_q[B_RX_OVER]);

  // R3
  tx_byte_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_byte |=> (stat_q[B_TX_EMPTY] && stat_q[B_RX_AVAIL]));

  // R5
  full_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rd || reg_wr) && lvl_rx_full) |=> stat_q[B_RX_FULL]);

  // R4
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~IMPL) == '0 && (en_q & ~IMPL) == '0);

endmodule

bind tgl_irq_unit tgl_irq_unit_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_overrun  (ev_overrun),
  .ev_tx_byte  (ev_tx_byte),
  .lvl_rx_full (lvl_rx_full),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .gie_q       (gie_q),
  .irq         (irq)
);

// File: tb/tgl_irq_unit_bench.sv
module tgl_irq_unit_bench;

  localparam int unsigned IMPL = 32'h0000_017C;

  logic        clk;
  logic        rst_n;
  logic        ev_tx_byte, ev_rx_fill, ev_overrun, ev_underrun, ev_half_empty;
  logic        lvl_rx_avail, lvl_rx_full;
  logic [1:0]  reg_sel;
  logic        reg_rd, reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int unsigned cmp_cnt;
  int unsigned bad_cnt;
  int unsigned cyc_cnt;
  bit          done;
  string       tag;

  // behavioural reference state
  int unsigned m_stat, m_en;
  bit          m_gie, m_irq;

  tgl_irq_unit u_tgl_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_byte(ev_tx_byte), .ev_rx_fill(ev_rx_fill), .ev_overrun(ev_overrun),
    .ev_underrun(ev_underrun), .ev_half_empty(ev_half_empty),
    .lvl_rx_avail(lvl_rx_avail), .lvl_rx_full(lvl_rx_full),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, bad_cnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000 && !done) begin
      done = 1'b1;
      bad_cnt++;
      cmp_cnt++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc_cnt);
      summary();
    end
  end

  function automatic int unsigned exp_rdata(logic [1:0] s);
    case (s)
      2'd0:    return m_stat;
      2'd1:    return m_en;
      2'd2:    return m_gie ? 32'h8000_0000 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string what, int unsigned act, int unsigned exp);
    cmp_cnt++;
    if (act != exp) begin
      bad_cnt++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // one clock: drive after falling edge, compare, then advance the model
  task automatic cyc(logic [4:0] ev, logic la, logic lf, logic rd, logic wr,
                     logic [1:0] s, logic [31:0] wd);
    int unsigned setv;
    int unsigned tog;
    @(negedge clk);
    {ev_tx_byte, ev_rx_fill, ev_overrun, ev_underrun, ev_half_empty} = ev;
    lvl_rx_avail = la; lvl_rx_full = lf;
    reg_rd = rd; reg_wr = wr; reg_sel = s; reg_wdata = wd;
    #1;
    check("rdata", reg_rdata, exp_rdata(s));
    check("irq", {31'b0, irq}, {31'b0, m_irq});
    @(posedge clk);
    m_irq = m_gie && ((m_stat & m_en) != 0);
    setv = 0;
    if (ev[4]) setv |= 32'h104;
    if (ev[3]) setv |= 32'h010;
    if (ev[2]) setv |= 32'h020;
    if (ev[1]) setv |= 32'h008;
    if (ev[0]) setv |= 32'h040;
    if ((rd || wr) && la) setv |= 32'h100;
    if ((rd || wr) && lf) setv |= 32'h010;
    tog = 0;
    if (wr && s == 2'd0) tog = wd & IMPL;
    if (wr && s == 2'd1) m_en = wd & IMPL;
    if (wr && s == 2'd2) m_gie = wd[31];
    m_stat = ((m_stat ^ tog) | setv) & IMPL;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(5'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0);
  endtask

  task automatic rd_reg(logic [1:0] s);
    cyc(5'b0, 1'b0, 1'b0, 1'b1, 1'b0, s, 32'h0);
  endtask

  task automatic wr_reg(logic [1:0] s, logic [31:0] v);
    cyc(5'b0, 1'b0, 1'b0, 1'b0, 1'b1, s, v);
  endtask

  initial begin
    cmp_cnt = 0; bad_cnt = 0; cyc_cnt = 0; done = 1'b0;
    m_stat = 0; m_en = 0; m_gie = 1'b0; m_irq = 1'b0;
    rst_n = 1'b0;
    {ev_tx_byte, ev_rx_fill, ev_overrun, ev_underrun, ev_half_empty} = '0;
    lvl_rx_avail = 1'b0; lvl_rx_full = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = '0;

    // R1: state while reset is held
    tag = "R1";
    repeat (3) @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      reg_sel = 2'(s);
      #1;
      check("reset rdata", reg_rdata, 32'h0);
    end
    check("reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    rd_reg(2'd0); rd_reg(2'd1); rd_reg(2'd2);

    // R2: single pulses, then status readback; sticky over idle cycles
    tag = "R2";
    cyc(5'b00100, 0, 0, 0, 0, 2'd3, 0);
    cyc(5'b00010, 0, 0, 0, 0, 2'd3, 0);
    cyc(5'b00001, 0, 0, 0, 0, 2'd3, 0);
    idle(3);
    rd_reg(2'd0);
    check("bits 3,5,6", reg_rdata, 32'h068);
    wr_reg(2'd0, 32'h068);

    // R3: transmitted byte and receive fill
    tag = "R3";
    cyc(5'b10000, 0, 0, 0, 0, 2'd3, 0);
    rd_reg(2'd0);
    check("tx byte bits 2,8", reg_rdata, 32'h104);
    cyc(5'b01000, 0, 0, 0, 0, 2'd3, 0);
    rd_reg(2'd0);
    check("rx fill bit 4", reg_rdata, 32'h114);

    // R4: XOR toggling, unimplemented bits stay zero
    tag = "R4";
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0);
    check("toggle all", reg_rdata, 32'h068);
    wr_reg(2'd0, 32'h0000_0068);
    rd_reg(2'd0);
    check("toggle back to zero", reg_rdata, 32'h0);

    // R5: levels ignored without access, captured on any access
    tag = "R5";
    cyc(5'b0, 1, 1, 0, 0, 2'd0, 0);
    cyc(5'b0, 1, 1, 0, 0, 2'd0, 0);
    rd_reg(2'd0);
    check("no capture without access", reg_rdata, 32'h0);
    cyc(5'b0, 1, 1, 0, 1, 2'd1, 32'h0);
    rd_reg(2'd0);
    check("capture on enable write", reg_rdata, 32'h110);
    wr_reg(2'd0, 32'h110);

    // R9: read returns pre-update value
    tag = "R9";
    cyc(5'b0, 1, 0, 1, 0, 2'd0, 0);
    check("read before capture", reg_rdata, 32'h0);
    rd_reg(2'd0);
    check("read after capture", reg_rdata, 32'h100);
    wr_reg(2'd0, 32'h100);

    // R6: event and toggle on the same bits in one cycle, levels high too
    tag = "R6";
    wr_reg(2'd0, 32'h010);
    cyc(5'b11000, 1, 1, 0, 1, 2'd0, 32'h114);
    rd_reg(2'd0);
    check("event beats toggle", reg_rdata, 32'h114);
    wr_reg(2'd0, 32'h114);

    // R7: enable and global enable registers
    tag = "R7";
    wr_reg(2'd1, 32'hFFFF_FFFF);
    rd_reg(2'd1);
    check("enable masked", reg_rdata, 32'h17C);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2);
    check("global bit31 only", reg_rdata, 32'h8000_0000);

    // R8: interrupt level and one-cycle latency
    tag = "R8";
    cyc(5'b00100, 0, 0, 0, 0, 2'd3, 0);
    idle(2);
    check("irq with overrun", {31'b0, irq}, 32'h1);
    wr_reg(2'd2, 32'h0);
    idle(2);
    check("irq gated by global", {31'b0, irq}, 32'h0);
    wr_reg(2'd2, 32'h8000_0000);
    wr_reg(2'd1, 32'h004);
    idle(2);
    check("irq masked off", {31'b0, irq}, 32'h0);
    wr_reg(2'd1, 32'h020);
    wr_reg(2'd0, 32'h020);
    idle(1);

    // R10: select 3 reads zero, writes ignored
    tag = "R10";
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_reg(2'd3);
    check("sel3 reads zero", reg_rdata, 32'h0);
    rd_reg(2'd0);
    check("status untouched", reg_rdata, 32'h0);
    rd_reg(2'd1);
    check("enable untouched", reg_rdata, 32'h020);

    // R8/R9: free collisions against the model
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  ev;
      logic [31:0] wd;
      logic [1:0]  s;
      ev = '0;
      for (int b = 0; b < 5; b++) ev[b] = ($urandom_range(0, 7) == 0);
      s  = 2'($urandom_range(0, 3));
      wd = $urandom;
      cyc(ev, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0), s, wd);
    end

    done = 1'b1;
    summary();
  end

endmodule